// File: doc/BRIEF.md
# External Trigger Conditioner

This block turns an asynchronous trigger pin into a clean level and edge signal that the timer can use. The raw pin first goes through a two-flop synchronizer. A polarity stage then makes the active sense of the signal high. Next comes an optional edge prescaler that divides the rate of active edges by 2, 4 or 8. The last stage is a digital glitch filter that accepts a new level only after N agreeing samples, taken at a selectable rate that is a fraction of the kernel clock.

The filtered level is registered and driven out. When external clocking is enabled, the block also issues a one-cycle pulse after every rising edge of the filtered level. The counter uses this pulse as its clock enable. All control inputs are static selects that can be changed while the block runs. A change of filter code restarts any qualification that is in progress.

Top module: `etr_cond`

## Requirements
- R1: With inversion off, prescaler code 0 and filter code 0, `etr_level` equals `etr_pin` delayed by exactly four clock cycles: two synchronizer flops, one prescaler stage and one filter register.
- R2: When `etr_invert` is 1, the pin is inverted before the prescaler, so low levels and falling pin edges become the active high level and the active rising edges.
- R3: Prescaler code 0 passes the polarity-corrected signal through the prescaler stage with a one-cycle register delay.
- R4: Prescaler codes 1, 2 and 3 count the active rising edges and divide their rate by 2, 4 and 8. The prescaler output toggles on the rising edge that completes each half period, which is 1, 2 or 4 counted edges.
- R5: Filter code 0 does no filtering: the filter register copies its input on every clock.
- R6: For a non-zero filter code, a sample is taken on each clock where the free-running 5-bit cycle counter, cleared by reset, is a multiple of the rate divisor. The output takes a new level on the Nth consecutive sample that differs from it. The code table gives (divisor, N) as follows:
  - 1: (1,2), 2: (1,4), 3: (1,8)
  - 4: (2,6), 5: (2,8)
  - 6: (4,6), 7: (4,8)
  - 8: (8,6), 9: (8,8)
  - 10: (16,5), 11: (16,6), 12: (16,8)
  - 13: (32,5), 14: (32,6), 15: (32,8)
- R7: A sample that agrees with the current output clears the agreement count, so a run of differing samples shorter than N never changes the output.
- R8: On a clock where the filter code differs from its value on the previous clock, the agreement count clears and the output holds.
- R9: `etr_pulse` is high for exactly one cycle, one clock after `etr_level` rises, and only if `ext_clk_en` was high on the clock of that rise. It never rises at any other time.
- R10: Synchronous reset clears every stage, so `etr_level` and `etr_pulse` are 0 during reset and on the first cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Kernel clock, also used as the filter base sampling clock |
| rst | input | 1 | Synchronous active-high reset |
| etr_pin | input | 1 | Raw asynchronous trigger pin |
| etr_invert | input | 1 | 1 inverts the pin, so low level and falling edges become active |
| psc_sel | input | 2 | Edge prescaler select: 0 bypass, 1 divide by 2, 2 divide by 4, 3 divide by 8 |
| flt_sel | input | 4 | Filter code selecting sample rate and required sample count |
| ext_clk_en | input | 1 | Enables the edge pulse used as an external counter clock |
| etr_level | output | 1 | Filtered, conditioned trigger level |
| etr_pulse | output | 1 | One-cycle pulse after each rising edge of `etr_level` |

## Verification
The pin is driven with random hold lengths. These mix short glitches of one to three cycles with long plateaus, under every filter code. Glitches separate a filter that counts consecutive samples from one that only counts samples. Long plateaus separate the sampling divisors from one another. A repeating pattern of three highs and one low under a four-sample filter shows whether disagreement clears the count. A code change partway through a qualification shows whether the count restarts. Fast square-ish pin activity under each prescaler code, with both polarities, tells the divide ratios apart. Random toggling of the enable checks that pulses follow only enabled rising edges.

// File: rtl/etr_pkg.sv
package etr_pkg;

  typedef struct packed {
    logic [2:0] rate_log;   // sample every 2**rate_log clocks
    logic [3:0] need;       // agreeing samples to accept a change
  } flt_cfg_t;

  function automatic flt_cfg_t flt_decode(input logic [3:0] code);
    flt_cfg_t c;
    case (code)
      4'd0:    c = '{rate_log: 3'd0, need: 4'd1};
      4'd1:    c = '{rate_log: 3'd0, need: 4'd2};
      4'd2:    c = '{rate_log: 3'd0, need: 4'd4};
      4'd3:    c = '{rate_log: 3'd0, need: 4'd8};
      4'd4:    c = '{rate_log: 3'd1, need: 4'd6};
      4'd5:    c = '{rate_log: 3'd1, need: 4'd8};
      4'd6:    c = '{rate_log: 3'd2, need: 4'd6};
      4'd7:    c = '{rate_log: 3'd2, need: 4'd8};
      4'd8:    c = '{rate_log: 3'd3, need: 4'd6};
      4'd9:    c = '{rate_log: 3'd3, need: 4'd8};
      4'd10:   c = '{rate_log: 3'd4, need: 4'd5};
      4'd11:   c = '{rate_log: 3'd4, need: 4'd6};
      4'd12:   c = '{rate_log: 3'd4, need: 4'd8};
      4'd13:   c = '{rate_log: 3'd5, need: 4'd5};
      4'd14:   c = '{rate_log: 3'd5, need: 4'd6};
      default: c = '{rate_log: 3'd5, need: 4'd8};
    endcase
    return c;
  endfunction

endpackage

// File: rtl/etr_sync.sv
module etr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[STAGES-2:0], d};
  end

  assign q = sh[STAGES-1];
endmodule

// File: rtl/etr_presc.sv
module etr_presc #(
  parameter int LOG_MAX = 3
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sig,
  input  logic [1:0] sel,
  output logic       out
);
  localparam int CW = (LOG_MAX > 1) ? LOG_MAX - 1 : 1;

  logic          sig_d;
  logic          q;
  logic [CW-1:0] cnt;
  logic [CW-1:0] lim;
  logic          rise;

  // R4: counted edges per half period, minus one
  always_comb begin
    if (sel == 2'd0) lim = '0;
    else             lim = CW'((1 << (sel - 2'd1)) - 1);
  end

  assign rise = sig & ~sig_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_d <= 1'b0;
      q     <= 1'b0;
      cnt   <= '0;
    end else begin
      sig_d <= sig;
      if (rise) begin
        if (cnt >= lim) begin
          cnt <= '0;
          q   <= ~q;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  // R3: bypass keeps the one-register delay of the divided path
  assign out = (sel == 2'd0) ? sig_d : q;
endmodule

// File: rtl/etr_filter.sv
module etr_filter
  import etr_pkg::*;
#(
  parameter int DIV_LOG_MAX = 5,
  parameter int CNT_W       = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       din,
  input  logic [3:0] sel,
  output logic       level,
  output logic       tick
);
  flt_cfg_t             cfg;
  logic [DIV_LOG_MAX-1:0] dcnt;
  logic [DIV_LOG_MAX-1:0] mask;
  logic [CNT_W-1:0]       agr;
  logic [CNT_W-1:0]       last;
  logic [3:0]             sel_d;

  always_comb begin
    cfg  = flt_decode(sel);
    mask = DIV_LOG_MAX'((1 << cfg.rate_log) - 1);
    last = CNT_W'(cfg.need) - 1'b1;
  end

  assign tick = ((dcnt & mask) == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      dcnt  <= '0;
      agr   <= '0;
      level <= 1'b0;
      sel_d <= '0;
    end else begin
      dcnt  <= dcnt + 1'b1;
      sel_d <= sel;
      if (sel != sel_d) begin
        agr <= '0;                      // R8
      end else if (sel == 4'd0) begin
        level <= din;                   // R5
        agr   <= '0;
      end else if (tick) begin
        if (din != level) begin
          if (agr == last) begin
            level <= din;               // R6
            agr   <= '0;
          end else begin
            agr <= agr + 1'b1;
          end
        end else begin
          agr <= '0;                    // R7
        end
      end
    end
  end
endmodule

// File: rtl/etr_cond.sv
module etr_cond #(
  parameter int SYNC_STAGES = 2,
  parameter int PSC_LOG_MAX = 3,
  parameter int FLT_DIV_LOG = 5,
  parameter int FLT_CNT_W   = 4
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       etr_pin,
  input  logic       etr_invert,
  input  logic [1:0] psc_sel,
  input  logic [3:0] flt_sel,
  input  logic       ext_clk_en,
  output logic       etr_level,
  output logic       etr_pulse
);
  logic pin_s;
  logic pol;
  logic presc_out;
  logic samp_tick;
  logic level_d;

  etr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (etr_pin),
    .q   (pin_s)
  );

  assign pol = pin_s ^ etr_invert;   // R2

  etr_presc #(.LOG_MAX(PSC_LOG_MAX)) u_presc (
    .clk (clk),
    .rst (rst),
    .sig (pol),
    .sel (psc_sel),
    .out (presc_out)
  );

  etr_filter #(.DIV_LOG_MAX(FLT_DIV_LOG), .CNT_W(FLT_CNT_W)) u_filt (
    .clk   (clk),
    .rst   (rst),
    .din   (presc_out),
    .sel   (flt_sel),
    .level (etr_level),
    .tick  (samp_tick)
  );

  // R9: registered edge pulse
  always_ff @(posedge clk) begin
    if (rst) begin
      level_d   <= 1'b0;
      etr_pulse <= 1'b0;
    end else begin
      level_d   <= etr_level;
      etr_pulse <= ext_clk_en & etr_level & ~level_d;
    end
  end
endmodule

// File: rtl/etr_cond_chk.sv
module etr_cond_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] flt_sel,
  input logic       ext_clk_en,
  input logic       etr_level,
  input logic       etr_pulse,
  input logic       filt_in,
  input logic       samp_tick
);
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (!etr_level && !etr_pulse));

  assert_pulse_single_R9: assert property (@(posedge clk) disable iff (rst)
    etr_pulse |=> !etr_pulse);

  assert_pulse_after_rise_R9: assert property (@(posedge clk) disable iff (rst)
    etr_pulse |-> ($past(etr_level) && !$past(etr_level, 2)));

  assert_pulse_gated_R9: assert property (@(posedge clk) disable iff (rst)
    !ext_clk_en |=> !etr_pulse);

  assert_hold_between_samples_R6: assert property (@(posedge clk) disable iff (rst)
    (flt_sel != 4'd0 && !samp_tick) |=> $stable(etr_level));

  assert_no_filter_copy_R5: assert property (@(posedge clk) disable iff (rst)
    (flt_sel == 4'd0 && $past(flt_sel) == 4'd0) |=> (etr_level == $past(filt_in)));
endmodule

bind etr_cond etr_cond_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .flt_sel    (flt_sel),
  .ext_clk_en (ext_clk_en),
  .etr_level  (etr_level),
  .etr_pulse  (etr_pulse),
  .filt_in    (presc_out),
  .samp_tick  (samp_tick)
);

// File: tb/tb_etr_cond.sv
module tb_etr_cond;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       etr_pin = 1'b0;
  logic       etr_invert = 1'b0;
  logic [1:0] psc_sel = 2'd0;
  logic [3:0] flt_sel = 4'd0;
  logic       ext_clk_en = 1'b0;
  logic       etr_level;
  logic       etr_pulse;

  int    n_checks = 0;
  int    n_fail   = 0;
  bit    finished = 0;
  bit    cmp_on   = 0;
  string tag      = "R10";

  always #(CLK_PERIOD/2) clk = ~clk;

  etr_cond dut (
    .clk        (clk),
    .rst        (rst),
    .etr_pin    (etr_pin),
    .etr_invert (etr_invert),
    .psc_sel    (psc_sel),
    .flt_sel    (flt_sel),
    .ext_clk_en (ext_clk_en),
    .etr_level  (etr_level),
    .etr_pulse  (etr_pulse)
  );

  // ---------------- behavioural reference ----------------
  bit sync_q[$];
  int m_pd, m_q, m_cnt, m_lvl, m_lvld, m_pulse, m_agr, m_seld, m_dc;

  function automatic int rate_of(int code);
    case (code)
      0, 1, 2, 3: return 1;
      4, 5:       return 2;
      6, 7:       return 4;
      8, 9:       return 8;
      10, 11, 12: return 16;
      default:    return 32;
    endcase
  endfunction

  function automatic int need_of(int code);
    case (code)
      0: return 1;
      1: return 2;
      2: return 4;
      4, 6, 8, 11, 14: return 6;
      10, 13: return 5;
      default: return 8;
    endcase
  endfunction

  initial begin
    sync_q = {1'b0, 1'b0};
  end

  always @(posedge clk) begin
    int p, fin, half, lim, code;
    if (rst) begin
      sync_q = {1'b0, 1'b0};
      m_pd = 0; m_q = 0; m_cnt = 0; m_lvl = 0; m_lvld = 0;
      m_pulse = 0; m_agr = 0; m_seld = 0; m_dc = 0;
    end else begin
      code = int'(flt_sel);
      p    = int'(sync_q[0]) ^ int'(etr_invert);
      fin  = (psc_sel == 2'd0) ? m_pd : m_q;
      if (p == 1 && m_pd == 0) begin
        half = (1 << psc_sel) / 2;
        lim  = (half > 0) ? half - 1 : 0;
        if (m_cnt >= lim) begin m_cnt = 0; m_q = 1 - m_q; end
        else m_cnt = m_cnt + 1;
      end
      m_pd = p;
      m_pulse = (ext_clk_en && m_lvl == 1 && m_lvld == 0) ? 1 : 0;
      m_lvld  = m_lvl;
      if (code != m_seld) m_agr = 0;
      else if (code == 0) begin m_lvl = fin; m_agr = 0; end
      else if (m_dc % rate_of(code) == 0) begin
        if (fin != m_lvl) begin
          m_agr = m_agr + 1;
          if (m_agr >= need_of(code)) begin m_lvl = fin; m_agr = 0; end
        end else m_agr = 0;
      end
      m_dc   = (m_dc + 1) % 32;
      m_seld = code;
      void'(sync_q.pop_front());
      sync_q.push_back(etr_pin);
    end
  end

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_on && !finished) begin
      check(tag, int'(etr_level), m_lvl);
      check("R9", int'(etr_pulse), m_pulse);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic random_run(input int cycles, input int max_hold);
    int left = cycles;
    while (left > 0) begin
      int h;
      if ($urandom % 4 == 0) h = 1 + int'($urandom % 3);
      else h = 1 + int'($urandom % max_hold);
      if (h > left) h = left;
      etr_pin = ~etr_pin;
      cyc(h);
      left -= h;
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * WATCHDOG);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R10: reset state with an active pin
    etr_pin = 1'b1;
    ext_clk_en = 1'b1;
    cyc(4);
    check("R10", int'(etr_level), 0);
    check("R10", int'(etr_pulse), 0);
    rst = 1'b0;
    etr_pin = 1'b0;
    cyc(1);
    check("R10", int'(etr_level), 0);
    check("R10", int'(etr_pulse), 0);
    cmp_on = 1;
    cyc(10);

    // R1 / R3 / R5: exact four-cycle latency with everything bypassed
    tag = "R1";
    etr_pin = 1'b1;
    cyc(3);
    check("R1", int'(etr_level), 0);
    cyc(1);
    check("R3", int'(etr_level), 1);
    check("R5", int'(etr_level), 1);
    cyc(1);
    check("R9", int'(etr_pulse), 1);
    cyc(1);
    check("R9", int'(etr_pulse), 0);
    random_run(1500, 12);

    // R2: inverted polarity
    tag = "R2";
    etr_invert = 1'b1;
    random_run(1500, 12);

    // R4: edge prescaler under both polarities
    tag = "R4";
    for (int s = 1; s < 4; s++) begin
      psc_sel = 2'(s);
      etr_invert = 1'b0;
      random_run(1500, 6);
      etr_invert = 1'b1;
      random_run(1500, 6);
    end

    // R6: every filter code with glitches and plateaus
    tag = "R6";
    for (int f = 1; f < 16; f++) begin
      flt_sel    = 4'(f);
      psc_sel    = (f < 8) ? 2'(f % 4) : 2'd0;
      etr_invert = f[0];
      random_run(1500 + 200 * f, 20 * (f + 1));
    end

    // R7: runs of three highs never reach four samples
    tag = "R7";
    psc_sel = 2'd0; etr_invert = 1'b0; etr_pin = 1'b0;
    flt_sel = 4'd2;
    cyc(20);
    for (int k = 0; k < 10; k++) begin
      etr_pin = 1'b1; cyc(3);
      etr_pin = 1'b0; cyc(1);
    end
    check("R7", int'(etr_level), 0);
    cyc(5);
    check("R7", int'(etr_level), 0);

    // R8: code change restarts qualification
    tag = "R8";
    flt_sel = 4'd3;
    cyc(20);
    etr_pin = 1'b1;
    cyc(8);
    flt_sel = 4'd2;
    cyc(4);
    check("R8", int'(etr_level), 0);
    cyc(1);
    check("R8", int'(etr_level), 1);
    cyc(10);
    for (int k = 0; k < 60; k++) begin
      flt_sel = 4'($urandom % 16);
      random_run(50 + int'($urandom % 100), 40);
    end

    // R9: enable toggling
    tag = "R6";
    flt_sel = 4'd1;
    for (int k = 0; k < 3000; k++) begin
      ext_clk_en = $urandom % 2;
      if ($urandom % 3 == 0) etr_pin = ~etr_pin;
      cyc(1);
    end
    ext_clk_en = 1'b1;

    // R10: mid-run reset
    tag = "R10";
    rst = 1'b1;
    cyc(3);
    check("R10", int'(etr_level), 0);
    rst = 1'b0;
    flt_sel = 4'd0;
    cyc(1);
    check("R10", int'(etr_pulse), 0);
    random_run(500, 10);
    cyc(5);
    finish_run();
  end
endmodule